// File: doc/BRIEF.md
# Drive LED Serial Frame Generator

This block drives a three-wire serial LED link (serial clock, frame load strobe and serial data) to a drive backplane. Software writes a control word that holds one byte per drive. Each byte gives a mode for the drive's activity, locate and fail LEDs. The block sends one bit per LED per bit slot, and repeats the frames back to back for as long as it is enabled. Each bit is worked out at the moment it is sent. The LED's mode selects from constant on or off, two blink generator inputs and their inversions, and the drive's activity input gated at frame boundaries.

The serial clock is derived from the block clock by a programmable divider. The frame length is programmable. Each of the three pins can be inverted on its own. The load strobe and the data can each be launched on the rising or on the falling serial clock edge. The control word, frame length and divider are sampled once per frame, so a change never splits a frame.

Top module: `led_frame_serializer`

## Requirements
- R1: A frame has `cfg_frame_len_m1`+1 bit slots, and frames follow each other with no gap. The load strobe is high in the first slot of each frame and low in every other slot. A field value of 11 gives the normal 12-slot frame.
- R2: Slot index b carries drive b/3, and drive 0 comes first. b%3 selects the LED: 0 is activity, 1 is locate, 2 is fail. Slots whose drive index is 4 or more carry 0.
- R3: Drive d takes control word bits [31-8d:24-8d]. In that byte, activity is bits [7:5], locate is bits [4:3] and fail is bits [2:0].
- R4: The 3-bit activity and fail modes are encoded as follows. 0 is off and 1 is on. 2 is blink A and 3 is blink A inverted. 4 is blink A ANDed with the drive's activity input sampled at frame start. 5 is blink A ANDed with the activity input sampled at the end of the previous frame, and 0 in the first frame after enabling. 6 is blink B and 7 is blink B inverted.
- R5: A locate code of 1 lights the locate bit. The codes 0, 2 and 3 send it as 0.
- R6: After reset the control word is 0x80808080: every activity mode is 4, and locate and fail are off.
- R7: The serial clock period is max(`cfg_clk_div`,2) block clock cycles. The clock is low for the first half of each slot.
- R8: Each of `cfg_inv_sclk`, `cfg_inv_sload` and `cfg_inv_sdout` inverts its own pin and no other.
- R9: Data changes only on the rising serial clock edge, or only on the falling edge when `cfg_sdout_fall` is set. The load strobe follows the same rule under `cfg_sload_fall`.
- R10: While `cfg_enable` is low, all pins stay at their inactive levels (0 XOR the inversion bit). Enabling the block starts a new frame at slot 0.
- R11: A control word written during a frame takes effect from the next frame. The frame in progress is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block (reference) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Master enable for the link |
| cfg_clk_div | input | DIV_W | Block clocks per serial clock period |
| cfg_frame_len_m1 | input | LEN_W | Bit slots per frame minus one |
| cfg_inv_sclk | input | 1 | Invert serial clock pin |
| cfg_inv_sload | input | 1 | Invert load strobe pin |
| cfg_inv_sdout | input | 1 | Invert serial data pin |
| cfg_sload_fall | input | 1 | Launch load strobe on the falling edge |
| cfg_sdout_fall | input | 1 | Launch data on the falling edge |
| ctrl_we | input | 1 | Write strobe for the drive control word |
| ctrl_wdata | input | 8*NUM_DRIVES | Drive control word write data |
| blink_a | input | 1 | Blink generator A level |
| blink_b | input | 1 | Blink generator B level |
| drive_active | input | NUM_DRIVES | Per-drive activity indication |
| sclk | output | 1 | Serial clock pin |
| sload | output | 1 | Frame load strobe pin |
| sdout | output | 1 | Serial data pin |

## Verification
The assertions check on every cycle the rules that depend only on timing. Pins sit idle while the block is disabled. The serial clock and both data lines move only at their slot events. The slot counters stay within the divider and the frame length. The frame shadow does not change inside a frame, and a locate code other than 1 never sends a 1. The decoded values themselves can only be shown by the bench's scenarios. These cover the mode encodings, the drive and LED order in the frame, the start-of-frame and end-of-frame activity gating, the measured clock period, the pin inversions, and a control word change taking effect only at the next frame. The bench decodes the pins at the sampling edge that matches the configured launch edge.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  localparam int LEDS_PER_DRIVE = 3;
  localparam logic [7:0] DRIVE_BYTE_RST = 8'h80;  // activity mode 4, others off
  localparam int DEFAULT_FRAME_M1 = 11;

  typedef enum logic [2:0] {
    LM_OFF     = 3'd0,
    LM_ON      = 3'd1,
    LM_BLA     = 3'd2,
    LM_BLA_N   = 3'd3,
    LM_BLA_SOF = 3'd4,
    LM_BLA_EOF = 3'd5,
    LM_BLB     = 3'd6,
    LM_BLB_N   = 3'd7
  } led_mode_e;

  typedef enum logic [1:0] {
    LK_ACT  = 2'd0,
    LK_LOC  = 2'd1,
    LK_FAIL = 2'd2,
    LK_NONE = 2'd3
  } led_kind_e;

  // Live value of one LED bit for a 3-bit mode.
  function automatic logic mode_eval(input led_mode_e m, input logic ba,
                                     input logic bb, input logic sof,
                                     input logic eof);
    case (m)
      LM_OFF:     return 1'b0;
      LM_ON:      return 1'b1;
      LM_BLA:     return ba;
      LM_BLA_N:   return ~ba;
      LM_BLA_SOF: return ba & sof;
      LM_BLA_EOF: return ba & eof;
      LM_BLB:     return bb;
      default:    return ~bb;
    endcase
  endfunction

  function automatic int unsigned slot_drive(input int unsigned idx);
    return idx / LEDS_PER_DRIVE;
  endfunction

  function automatic led_kind_e slot_kind(input int unsigned idx);
    case (idx % LEDS_PER_DRIVE)
      0:       return LK_ACT;
      1:       return LK_LOC;
      default: return LK_FAIL;
    endcase
  endfunction

endpackage

// File: rtl/lfs_clk_div.sv
module lfs_clk_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_eff,
  output logic             slot_start,
  output logic             mid_ev,
  output logic             slot_end,
  output logic             sclk_lvl
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;

  assign half       = div_eff >> 1;
  assign slot_start = en && (cnt == '0);
  assign mid_ev     = en && (cnt == half);
  assign slot_end   = en && (cnt == (div_eff - DIV_W'(1)));
  assign sclk_lvl   = (cnt >= half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!en)      cnt <= '0;
    else if (slot_end) cnt <= '0;
    else               cnt <= cnt + DIV_W'(1);
  end

  // R7: the slot counter never passes the divider in use
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < div_eff));

endmodule

// File: rtl/lfs_frame_seq.sv
module lfs_frame_seq #(
  parameter int NUM_DRIVES = 4,
  parameter int DIV_W      = 16,
  parameter int LEN_W      = 5,
  localparam int CTRL_W    = 8 * NUM_DRIVES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  slot_start,
  input  logic                  slot_end,
  input  logic [CTRL_W-1:0]     ctrl_in,
  input  logic [DIV_W-1:0]      div_in,
  input  logic [LEN_W-1:0]      len_in,
  input  logic [NUM_DRIVES-1:0] drive_active,
  output logic                  frame_start,
  output logic [LEN_W-1:0]      bit_idx,
  output logic [CTRL_W-1:0]     ctrl_eff,
  output logic [DIV_W-1:0]      div_eff,
  output logic [LEN_W-1:0]      len_eff,
  output logic [NUM_DRIVES-1:0] sof_eff,
  output logic [NUM_DRIVES-1:0] eof_q
);
  import lfs_pkg::*;

  logic [CTRL_W-1:0]     ctrl_q;
  logic [DIV_W-1:0]      div_q;
  logic [LEN_W-1:0]      len_q;
  logic [NUM_DRIVES-1:0] sof_q;

  assign frame_start = en && slot_start && (bit_idx == '0);
  // the frame that starts in this cycle already uses the new values
  assign ctrl_eff = frame_start ? ctrl_in      : ctrl_q;
  assign div_eff  = frame_start ? div_in       : div_q;
  assign len_eff  = frame_start ? len_in       : len_q;
  assign sof_eff  = frame_start ? drive_active : sof_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      ctrl_q  <= {NUM_DRIVES{DRIVE_BYTE_RST}};
      div_q   <= DIV_W'(2);
      len_q   <= LEN_W'(DEFAULT_FRAME_M1);
      sof_q   <= '0;
      eof_q   <= '0;
    end else if (!en) begin
      bit_idx <= '0;
      eof_q   <= '0;
    end else begin
      if (frame_start) begin
        ctrl_q <= ctrl_in;
        div_q  <= div_in;
        len_q  <= len_in;
        sof_q  <= drive_active;
      end
      if (slot_end) begin
        if (bit_idx == len_eff) begin
          bit_idx <= '0;
          eof_q   <= drive_active;
        end else begin
          bit_idx <= bit_idx + LEN_W'(1);
        end
      end
    end
  end

  // R11: shadow copy moves only at a frame start
  p_shadow_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(ctrl_q) && $stable(len_q) && $stable(div_q)));

  // R1: slot index stays inside the frame in use
  p_slot_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (bit_idx <= len_eff));

endmodule

// File: rtl/lfs_bit_mux.sv
module lfs_bit_mux #(
  parameter int NUM_DRIVES = 4,
  parameter int LEN_W      = 5,
  localparam int CTRL_W    = 8 * NUM_DRIVES
) (
  input  logic [LEN_W-1:0]      bit_idx,
  input  logic [CTRL_W-1:0]     ctrl,
  input  logic [NUM_DRIVES-1:0] sof,
  input  logic [NUM_DRIVES-1:0] eof,
  input  logic                  ba,
  input  logic                  bb,
  output logic                  led_bit,
  output lfs_pkg::led_kind_e    kind,
  output logic [1:0]            loc_code
);
  import lfs_pkg::*;

  logic [NUM_DRIVES-1:0] act_b;
  logic [NUM_DRIVES-1:0] loc_b;
  logic [NUM_DRIVES-1:0] fail_b;
  logic [1:0]            loc_raw [NUM_DRIVES];

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
    logic [7:0] by;
    assign by         = ctrl[(NUM_DRIVES-1-g)*8 +: 8];
    assign act_b[g]   = mode_eval(led_mode_e'(by[7:5]), ba, bb, sof[g], eof[g]);
    assign loc_b[g]   = (by[4:3] == 2'd1);
    assign fail_b[g]  = mode_eval(led_mode_e'(by[2:0]), ba, bb, sof[g], eof[g]);
    assign loc_raw[g] = by[4:3];
  end

  int unsigned drv;
  led_kind_e   k_raw;

  always_comb begin
    drv      = slot_drive(32'(bit_idx));
    k_raw    = slot_kind(32'(bit_idx));
    led_bit  = 1'b0;
    loc_code = 2'd0;
    kind     = LK_NONE;
    for (int unsigned d = 0; d < NUM_DRIVES; d++) begin
      if (drv == d) begin
        kind     = k_raw;
        loc_code = loc_raw[d];
        case (k_raw)
          LK_ACT:  led_bit = act_b[d];
          LK_LOC:  led_bit = loc_b[d];
          default: led_bit = fail_b[d];
        endcase
      end
    end
  end

endmodule

// File: rtl/led_frame_serializer.sv
module led_frame_serializer #(
  parameter int NUM_DRIVES = 4,
  parameter int DIV_W      = 16,
  parameter int LEN_W      = 5,
  localparam int CTRL_W    = 8 * NUM_DRIVES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_enable,
  input  logic [DIV_W-1:0]      cfg_clk_div,
  input  logic [LEN_W-1:0]      cfg_frame_len_m1,
  input  logic                  cfg_inv_sclk,
  input  logic                  cfg_inv_sload,
  input  logic                  cfg_inv_sdout,
  input  logic                  cfg_sload_fall,
  input  logic                  cfg_sdout_fall,
  input  logic                  ctrl_we,
  input  logic [CTRL_W-1:0]     ctrl_wdata,
  input  logic                  blink_a,
  input  logic                  blink_b,
  input  logic [NUM_DRIVES-1:0] drive_active,
  output logic                  sclk,
  output logic                  sload,
  output logic                  sdout
);
  import lfs_pkg::*;

  logic [CTRL_W-1:0] ctrl_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_reg <= {NUM_DRIVES{DRIVE_BYTE_RST}};
    else if (ctrl_we) ctrl_reg <= ctrl_wdata;
  end

  logic [DIV_W-1:0] div_in;
  assign div_in = (cfg_clk_div < DIV_W'(2)) ? DIV_W'(2) : cfg_clk_div;

  // events between the pieces, kept visible for the assertions
  logic                  slot_start, mid_ev, slot_end, sclk_lvl;
  logic                  frame_start;
  logic [LEN_W-1:0]      bit_idx, len_eff;
  logic [DIV_W-1:0]      div_eff;
  logic [CTRL_W-1:0]     ctrl_eff;
  logic [NUM_DRIVES-1:0] sof_eff, eof_q;
  logic                  led_bit;
  led_kind_e             kind;
  logic [1:0]            loc_code;

  lfs_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (cfg_enable),
    .div_eff    (div_eff),
    .slot_start (slot_start),
    .mid_ev     (mid_ev),
    .slot_end   (slot_end),
    .sclk_lvl   (sclk_lvl)
  );

  lfs_frame_seq #(.NUM_DRIVES(NUM_DRIVES), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (cfg_enable),
    .slot_start   (slot_start),
    .slot_end     (slot_end),
    .ctrl_in      (ctrl_reg),
    .div_in       (div_in),
    .len_in       (cfg_frame_len_m1),
    .drive_active (drive_active),
    .frame_start  (frame_start),
    .bit_idx      (bit_idx),
    .ctrl_eff     (ctrl_eff),
    .div_eff      (div_eff),
    .len_eff      (len_eff),
    .sof_eff      (sof_eff),
    .eof_q        (eof_q)
  );

  lfs_bit_mux #(.NUM_DRIVES(NUM_DRIVES), .LEN_W(LEN_W)) u_mux (
    .bit_idx  (bit_idx),
    .ctrl     (ctrl_eff),
    .sof      (sof_eff),
    .eof      (eof_q),
    .ba       (blink_a),
    .bb       (blink_b),
    .led_bit  (led_bit),
    .kind     (kind),
    .loc_code (loc_code)
  );

  logic sd_launch, sl_launch;
  assign sd_launch = cfg_sdout_fall ? slot_start : mid_ev;
  assign sl_launch = cfg_sload_fall ? slot_start : mid_ev;

  logic sclk_raw_q, sload_raw_q, sdout_raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_raw_q  <= 1'b0;
      sload_raw_q <= 1'b0;
      sdout_raw_q <= 1'b0;
    end else if (!cfg_enable) begin
      sclk_raw_q  <= 1'b0;
      sload_raw_q <= 1'b0;
      sdout_raw_q <= 1'b0;
    end else begin
      sclk_raw_q <= sclk_lvl;
      if (sd_launch) sdout_raw_q <= led_bit;
      if (sl_launch) sload_raw_q <= (bit_idx == '0);
    end
  end

  assign sclk  = sclk_raw_q  ^ cfg_inv_sclk;
  assign sload = sload_raw_q ^ cfg_inv_sload;
  assign sdout = sdout_raw_q ^ cfg_inv_sdout;

  // R10: disabled link leaves every line inactive
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!sclk_raw_q && !sload_raw_q && !sdout_raw_q));

  // R9: data moves only at its launch event
  p_sdout_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && !sd_launch) |=> $stable(sdout_raw_q));

  // R9: load strobe moves only at its launch event
  p_sload_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && !sl_launch) |=> $stable(sload_raw_q));

  // R7: serial clock toggles only at slot start or mid-slot
  p_sclk_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && !slot_start && !mid_ev) |=> $stable(sclk_raw_q));

  // R5: locate codes other than 1 never send a one
  p_locate_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_launch && kind == LK_LOC && loc_code != 2'd1) |=> !sdout_raw_q);

endmodule

// File: tb/led_frame_serializer_tb.sv
module led_frame_serializer_tb;
  localparam int ND = 4;
  localparam int DW = 16;
  localparam int LW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          cfg_enable;
  logic [DW-1:0] cfg_clk_div;
  logic [LW-1:0] cfg_frame_len_m1;
  logic          cfg_inv_sclk, cfg_inv_sload, cfg_inv_sdout;
  logic          cfg_sload_fall, cfg_sdout_fall;
  logic          ctrl_we;
  logic [31:0]   ctrl_wdata;
  logic          blink_a, blink_b;
  logic [ND-1:0] drive_active;
  logic          sclk, sload, sdout;

  led_frame_serializer #(.NUM_DRIVES(ND), .DIV_W(DW), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_clk_div(cfg_clk_div),
    .cfg_frame_len_m1(cfg_frame_len_m1), .cfg_inv_sclk(cfg_inv_sclk),
    .cfg_inv_sload(cfg_inv_sload), .cfg_inv_sdout(cfg_inv_sdout),
    .cfg_sload_fall(cfg_sload_fall), .cfg_sdout_fall(cfg_sdout_fall),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .blink_a(blink_a), .blink_b(blink_b),
    .drive_active(drive_active), .sclk(sclk), .sload(sload), .sdout(sdout)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected LED bit, worked out from the requirement text
  function automatic logic exp_bit(input logic [31:0] cw, input int b, input logic [3:0] sof,
                                   input logic [3:0] eof, input logic ba, input logic bb);
    int d = b / 3;
    int k = b % 3;
    logic [7:0] by;
    int m;
    if (d >= 4) return 1'b0;
    by = cw[8*(3-d) +: 8];
    if (k == 1) return by[4:3] == 2'b01;
    m = (k == 0) ? int'(by[7:5]) : int'(by[2:0]);
    case (m)
      0: return 1'b0;
      1: return 1'b1;
      2: return ba;
      3: return !ba;
      4: return ba & sof[d];
      5: return ba & eof[d];
      6: return bb;
      default: return !bb;
    endcase
  endfunction

  function automatic logic [31:0] rot_word(input int m);
    logic [31:0] w = '0;
    for (int d = 0; d < 4; d++) begin
      logic [7:0] by;
      by = {3'((m + d) % 8), 2'((m + d) % 4), 3'((m + 2*d + 3) % 8)};
      w[8*(3-d) +: 8] = by;
    end
    return w;
  endfunction

  // inv = {sclk,sload,sdout}; fall = {sload_fall,sdout_fall}
  task automatic run_scn(input string tag, input bit do_wr, input logic [31:0] ca,
                         input logic [31:0] cb, input int lm1, input int dv,
                         input logic [3:0] da, input logic ba, input logic bb,
                         input logic [2:0] inv, input logic [1:0] fall, input int nfr);
    int L = lm1 + 1;
    int per = (dv < 2) ? 2 : dv;
    int total = nfr * L;
    int sd_n = 0, sl_n = 0, cyc = 0, rise_cnt = 0, first_rise = 0, per_meas = -1, edge_bad = 0;
    bit ps = 0, pd = 0, pl = 0, s, d, l, rise, fall_e;
    @(negedge clk);
    cfg_enable = 1'b0;
    cfg_clk_div = DW'(dv);
    cfg_frame_len_m1 = LW'(lm1);
    {cfg_inv_sclk, cfg_inv_sload, cfg_inv_sdout} = inv;
    {cfg_sload_fall, cfg_sdout_fall} = fall;
    drive_active = da; blink_a = ba; blink_b = bb;
    if (do_wr) begin
      ctrl_we = 1'b1; ctrl_wdata = ca;
      @(negedge clk);
      ctrl_we = 1'b0;
    end
    @(negedge clk);
    @(negedge clk);
    chk({sclk, sload, sdout} == inv, {"R10/R8 idle pins ", tag}, {sclk, sload, sdout}, inv);
    cfg_enable = 1'b1;
    while ((sd_n < total || sl_n < total) && cyc < 20000) begin
      @(negedge clk);
      ctrl_we = 1'b0;
      cyc++;
      s = sclk ^ inv[2]; l = sload ^ inv[1]; d = sdout ^ inv[0];
      rise = !ps && s;
      fall_e = ps && !s;
      if (rise_cnt > 0) begin
        if (d != pd && !(fall[0] ? fall_e : rise)) edge_bad++;
        if (l != pl && !(fall[1] ? fall_e : rise)) edge_bad++;
      end
      if (rise) begin
        rise_cnt++;
        if (rise_cnt == 1) first_rise = cyc;
        else if (rise_cnt == 2) per_meas = cyc - first_rise;
      end
      if ((fall[0] ? rise : fall_e) && sd_n < total) begin
        int f = sd_n / L;
        int b = sd_n % L;
        logic e;
        e = exp_bit((f >= 2) ? cb : ca, b, da, (f == 0) ? 4'b0000 : da, ba, bb);
        chk(d == e, $sformatf("R2/R3/R4/R11 data %s frame %0d slot %0d", tag, f, b), d, e);
        sd_n++;
        if (sd_n == L + 2 && do_wr) begin
          ctrl_we = 1'b1; ctrl_wdata = cb;
        end
      end
      if ((fall[1] ? rise : fall_e) && sl_n < total) begin
        logic e;
        e = ((sl_n % L) == 0);
        chk(l == e, $sformatf("R1 load strobe %s slot %0d", tag, sl_n), l, e);
        sl_n++;
      end
      ps = s; pd = d; pl = l;
    end
    if (cyc >= 20000) chk(1'b0, {"watchdog ", tag}, cyc, 0);
    chk(per_meas == per, {"R7 clock period ", tag}, per_meas, per);
    chk(edge_bad == 0, {"R9 launch edge ", tag}, edge_bad, 0);
    cfg_enable = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_enable = 1'b0; cfg_clk_div = DW'(4); cfg_frame_len_m1 = LW'(11);
    cfg_inv_sclk = 0; cfg_inv_sload = 0; cfg_inv_sdout = 0;
    cfg_sload_fall = 0; cfg_sdout_fall = 0; ctrl_we = 0; ctrl_wdata = '0;
    blink_a = 0; blink_b = 0; drive_active = '0;
    repeat (3) @(negedge clk);
    chk({sclk, sload, sdout} == 3'b000, "R10 pins in reset", {sclk, sload, sdout}, 0);
    rst_n = 1'b1;

    // R6: reset control word, no write
    run_scn("R6 reset word", 1'b0, 32'h80808080, 32'h80808080, 11, 4, 4'b1011,
            1'b1, 1'b0, 3'b000, 2'b00, 3);

    // R4/R5: all modes on every drive position, every blink combination
    for (int m = 0; m < 8; m++) begin
      for (int bl = 0; bl < 4; bl++) begin
        run_scn($sformatf("R4 mode sweep m%0d bl%0d", m, bl), 1'b1, rot_word(m),
                rot_word(m + 5), 11, 2 + (m % 3), (bl[0] ? 4'b0110 : 4'b1001),
                bl[0], bl[1], 3'b000, 2'(m), 3);
      end
    end

    // R8/R9: every inversion and edge option
    for (int p = 0; p < 32; p++) begin
      run_scn($sformatf("R8 pin options %0d", p), 1'b1, 32'h5A3CE197, 32'h5A3CE197,
              11, 3, 4'b1100, 1'b1, 1'b0, 3'(p), 2'(p >> 3), 2);
    end

    // R1/R2/R11: frame lengths, including slots beyond the last drive
    run_scn("R1 len1", 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 5, 4'hF, 1, 1, 3'b000, 2'b00, 4);
    run_scn("R1 len2", 1'b1, 32'h2BFFFFFF, 32'h2BFFFFFF, 1, 5, 4'hF, 1, 0, 3'b000, 2'b11, 4);
    run_scn("R11 len6", 1'b1, 32'h29492949, 32'hC7D0E8FF, 5, 5, 4'hA, 1, 0, 3'b000, 2'b01, 4);
    run_scn("R2 len14", 1'b1, 32'h3F3F3F3F, 32'hFFFFFFFF, 13, 2, 4'h5, 0, 1, 3'b000, 2'b10, 3);
    run_scn("R2 len17", 1'b1, 32'hFFFFFFFF, 32'h24242424, 16, 3, 4'hF, 1, 0, 3'b000, 2'b00, 3);

    // R7: divider clamp and larger divider
    run_scn("R7 div0", 1'b1, 32'h20202020, 32'h20202020, 11, 0, 4'h0, 1, 0, 3'b000, 2'b00, 2);
    run_scn("R7 div1", 1'b1, 32'h20202020, 32'h20202020, 11, 1, 4'h0, 1, 0, 3'b000, 2'b01, 2);
    run_scn("R7 div9", 1'b1, 32'hE0C0A040, 32'h0E0C0A04, 11, 9, 4'h3, 1, 1, 3'b000, 2'b10, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule